// File: doc/BRIEF.md
# In-Order Commitment Unit

This block sits between dispatch and the architectural register file of a core whose execution units finish out of program order. Up to two instructions enter per cycle, one for an integer unit and one for a floating-point unit. Each gets a tag that marks its place in program order. Integer work finishes after one cycle and floating-point work after three, so a younger instruction often completes before an older one. Its result is parked in a temporary slot, not in the register file.

The unit retires parked results to the register file strictly in program order, at most two per cycle, through two write ports. An instruction retires only after every older instruction has retired. When the oldest live instruction reported an exception, it is not written. Instead the unit raises a flush that carries that instruction's tag and discards every younger instruction, so the visible state stays precise. Slots form a circular buffer of eight entries. Dispatch is held off while fewer than two slots are free.

Top module: `commit_unit`

## Requirements
- R1: After reset the buffer is empty: `disp_ready` is 1, `cmt0_valid`, `cmt1_valid` and `flush_valid` are 0, and both dispatch tags read 0.
- R2: A tag is the slot index (0 to 7). The integer request takes the tail slot. The floating-point request takes the slot after it when both are accepted together, and the tail slot when it is accepted alone. The tail moves on by the number accepted, modulo 8.
- R3: `disp_ready` is 1 only when at most DEPTH-2 (6) slots are occupied and no flush is being signalled. Requests made while it is 0 are dropped and consume no tag.
- R4: Completion reports may arrive in any order. A completed entry is never written to the register file while an older entry is still outstanding.
- R5: Port 0 presents the destination and result of the oldest entry. It does so in the cycle after the clock edge that captured that entry's completion, provided the entry has no exception, and the entry leaves the buffer at the following edge.
- R6: Port 1 carries the entry right after the oldest, in the same cycle, only when both are complete and neither has an exception. `cmt1_valid` is never 1 without `cmt0_valid`.
- R7: If the oldest entry completed with an exception, `flush_valid` is 1 and `flush_tag` is its tag, and neither commit port is valid. From the next cycle on, the buffer is empty, the next tag issued is 0, and no younger entry is ever written.
- R8: If the oldest entry is clean and the next one carries an exception, the oldest retires alone on port 0, and the flush for the next one follows in the cycle after.
- R9: A completion report naming a slot that holds no live entry is ignored. A later entry dispatched into that slot still waits for its own completion.
- R10: Dispatch and retirement in the same cycle both take effect. Readiness is judged on the occupancy before that cycle's retirements.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_int_valid | input | 1 | Integer instruction dispatched |
| disp_int_dest | input | 5 | Integer destination register |
| disp_fp_valid | input | 1 | Floating-point instruction dispatched |
| disp_fp_dest | input | 5 | Floating-point destination register |
| disp_ready | output | 1 | Two or more slots free and no flush |
| disp_int_tag | output | 3 | Tag given to the integer request |
| disp_fp_tag | output | 3 | Tag given to the floating-point request |
| cpl_int_valid | input | 1 | Integer unit finished an instruction |
| cpl_int_tag | input | 3 | Tag of the finished integer instruction |
| cpl_int_data | input | 32 | Integer result |
| cpl_int_exc | input | 1 | Integer instruction raised an exception |
| cpl_fp_valid | input | 1 | Floating-point unit finished an instruction |
| cpl_fp_tag | input | 3 | Tag of the finished floating-point instruction |
| cpl_fp_data | input | 32 | Floating-point result |
| cpl_fp_exc | input | 1 | Floating-point instruction raised an exception |
| cmt0_valid | output | 1 | Register write of the oldest entry |
| cmt0_dest | output | 5 | Destination of port 0 write |
| cmt0_data | output | 32 | Data of port 0 write |
| cmt1_valid | output | 1 | Register write of the second-oldest entry |
| cmt1_dest | output | 5 | Destination of port 1 write |
| cmt1_data | output | 32 | Data of port 1 write |
| flush_valid | output | 1 | Precise exception: discard all younger work |
| flush_tag | output | 3 | Tag of the excepting instruction |

## Verification
Retirement at the head and acceptance of new work at the tail can occur in the same cycle, and the slot count must absorb both. The bench provokes this by completing the two oldest of six entries and then dispatching a new pair in the very cycle those two retire. A scoreboard holding program order checks that readiness is judged on the pre-retirement occupancy, that the new tags follow the tail, and that every entry later leaves in order with its own data. It also checks an exception at the head against a dispatch attempt made in that flush cycle, which must be refused.

// File: rtl/commit_pkg.sv
package commit_pkg;

    // Outcome of the head examination in one cycle
    typedef enum logic [1:0] {
        RET_IDLE  = 2'd0,
        RET_ONE   = 2'd1,
        RET_TWO   = 2'd2,
        RET_FLUSH = 2'd3
    } retire_e;

endpackage

// File: rtl/rob_slots.sv
module rob_slots #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 32,
    parameter int REG_W  = 5,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            clear_all,
    input  logic                            alloc_a_en,
    input  logic [IDX_W-1:0]                alloc_a_idx,
    input  logic [REG_W-1:0]                alloc_a_dest,
    input  logic                            alloc_b_en,
    input  logic [IDX_W-1:0]                alloc_b_idx,
    input  logic [REG_W-1:0]                alloc_b_dest,
    input  logic                            cpl_a_en,
    input  logic [IDX_W-1:0]                cpl_a_idx,
    input  logic [DATA_W-1:0]               cpl_a_data,
    input  logic                            cpl_a_exc,
    input  logic                            cpl_b_en,
    input  logic [IDX_W-1:0]                cpl_b_idx,
    input  logic [DATA_W-1:0]               cpl_b_data,
    input  logic                            cpl_b_exc,
    input  logic [DEPTH-1:0]                release_mask,
    output logic [DEPTH-1:0]                slot_valid,
    output logic [DEPTH-1:0]                slot_done,
    output logic [DEPTH-1:0]                slot_exc,
    output logic [DEPTH-1:0][REG_W-1:0]     slot_dest,
    output logic [DEPTH-1:0][DATA_W-1:0]    slot_data
);

    typedef struct packed {
        logic              valid;
        logic              done;
        logic              exc;
        logic [REG_W-1:0]  dest;
        logic [DATA_W-1:0] data;
    } slot_t;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        slot_t s_d, s_q;
        logic  hit_alloc_a, hit_alloc_b, hit_cpl_a, hit_cpl_b;

        always_comb begin
            hit_alloc_a = alloc_a_en && (alloc_a_idx == IDX_W'(g));
            hit_alloc_b = alloc_b_en && (alloc_b_idx == IDX_W'(g));
            hit_cpl_a   = cpl_a_en && (cpl_a_idx == IDX_W'(g)) && s_q.valid;
            hit_cpl_b   = cpl_b_en && (cpl_b_idx == IDX_W'(g)) && s_q.valid;

            s_d = s_q;
            if (release_mask[g]) begin
                s_d.valid = 1'b0;
                s_d.done  = 1'b0;
                s_d.exc   = 1'b0;
            end
            if (hit_alloc_a || hit_alloc_b) begin
                s_d.valid = 1'b1;
                s_d.done  = 1'b0;
                s_d.exc   = 1'b0;
                s_d.dest  = hit_alloc_a ? alloc_a_dest : alloc_b_dest;
            end
            if (hit_cpl_a) begin
                s_d.done = 1'b1;
                s_d.exc  = cpl_a_exc;
                s_d.data = cpl_a_data;
            end
            if (hit_cpl_b) begin
                s_d.done = 1'b1;
                s_d.exc  = cpl_b_exc;
                s_d.data = cpl_b_data;
            end
            if (clear_all) begin
                s_d.valid = 1'b0;
                s_d.done  = 1'b0;
                s_d.exc   = 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) s_q <= '0;
            else        s_q <= s_d;
        end

        assign slot_valid[g] = s_q.valid;
        assign slot_done[g]  = s_q.done;
        assign slot_exc[g]   = s_q.exc;
        assign slot_dest[g]  = s_q.dest;
        assign slot_data[g]  = s_q.data;

        // Dispatch must never land on a live entry
        AST_ALLOC_FREE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
            (hit_alloc_a || hit_alloc_b) |-> !s_q.valid); // R3
    end

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clear_all |=> (slot_valid == '0)); // R7

endmodule

// File: rtl/head_select.sv
module head_select
    import commit_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 32,
    parameter int REG_W  = 5,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic [IDX_W-1:0]             head_idx,
    input  logic [DEPTH-1:0]             slot_valid,
    input  logic [DEPTH-1:0]             slot_done,
    input  logic [DEPTH-1:0]             slot_exc,
    input  logic [DEPTH-1:0][REG_W-1:0]  slot_dest,
    input  logic [DEPTH-1:0][DATA_W-1:0] slot_data,
    output retire_e                      decision,
    output logic [IDX_W-1:0]             next_idx,
    output logic [REG_W-1:0]             old_dest,
    output logic [DATA_W-1:0]            old_data,
    output logic [REG_W-1:0]             young_dest,
    output logic [DATA_W-1:0]            young_data
);

    logic head_ready, next_ready;

    always_comb begin
        next_idx   = (head_idx == IDX_W'(DEPTH - 1)) ? '0 : head_idx + 1'b1;
        head_ready = slot_valid[head_idx] && slot_done[head_idx];
        next_ready = slot_valid[next_idx] && slot_done[next_idx] && !slot_exc[next_idx];

        if (head_ready && slot_exc[head_idx]) decision = RET_FLUSH;
        else if (head_ready && next_ready)    decision = RET_TWO;
        else if (head_ready)                  decision = RET_ONE;
        else                                  decision = RET_IDLE;

        old_dest   = slot_dest[head_idx];
        old_data   = slot_data[head_idx];
        young_dest = slot_dest[next_idx];
        young_data = slot_data[next_idx];
    end

endmodule

// File: rtl/commit_unit.sv
module commit_unit
    import commit_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 32,
    parameter int REG_W  = 5,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              disp_int_valid,
    input  logic [REG_W-1:0]  disp_int_dest,
    input  logic              disp_fp_valid,
    input  logic [REG_W-1:0]  disp_fp_dest,
    output logic              disp_ready,
    output logic [IDX_W-1:0]  disp_int_tag,
    output logic [IDX_W-1:0]  disp_fp_tag,
    input  logic              cpl_int_valid,
    input  logic [IDX_W-1:0]  cpl_int_tag,
    input  logic [DATA_W-1:0] cpl_int_data,
    input  logic              cpl_int_exc,
    input  logic              cpl_fp_valid,
    input  logic [IDX_W-1:0]  cpl_fp_tag,
    input  logic [DATA_W-1:0] cpl_fp_data,
    input  logic              cpl_fp_exc,
    output logic              cmt0_valid,
    output logic [REG_W-1:0]  cmt0_dest,
    output logic [DATA_W-1:0] cmt0_data,
    output logic              cmt1_valid,
    output logic [REG_W-1:0]  cmt1_dest,
    output logic [DATA_W-1:0] cmt1_data,
    output logic              flush_valid,
    output logic [IDX_W-1:0]  flush_tag
);

    localparam logic [CNT_W-1:0] STALL_AT = CNT_W'(DEPTH - 2);
    localparam logic [CNT_W-1:0] FULL_AT  = CNT_W'(DEPTH);

    typedef struct packed {
        logic [IDX_W-1:0] head;
        logic [IDX_W-1:0] tail;
        logic [CNT_W-1:0] count;
    } ptr_t;

    ptr_t ptr_d, ptr_q;

    logic [DEPTH-1:0]             slot_valid, slot_done, slot_exc;
    logic [DEPTH-1:0][REG_W-1:0]  slot_dest;
    logic [DEPTH-1:0][DATA_W-1:0] slot_data;
    logic [DEPTH-1:0]             release_mask;
    retire_e                      decision;
    logic [IDX_W-1:0]             next_idx;
    logic [REG_W-1:0]             old_dest, young_dest;
    logic [DATA_W-1:0]            old_data, young_data;
    logic                         int_go, fp_go;
    logic [1:0]                   n_go, n_ret;

    function automatic logic [IDX_W-1:0] wrap_add(input logic [IDX_W-1:0] base,
                                                  input logic [1:0]       step);
        logic [IDX_W+1:0] sum;
        sum = {2'b00, base} + {{IDX_W{1'b0}}, step};
        if (sum >= (IDX_W+2)'(DEPTH)) sum = sum - (IDX_W+2)'(DEPTH);
        return sum[IDX_W-1:0];
    endfunction

    head_select #(.DEPTH(DEPTH), .DATA_W(DATA_W), .REG_W(REG_W)) u_sel (
        .head_idx   (ptr_q.head),
        .slot_valid (slot_valid),
        .slot_done  (slot_done),
        .slot_exc   (slot_exc),
        .slot_dest  (slot_dest),
        .slot_data  (slot_data),
        .decision   (decision),
        .next_idx   (next_idx),
        .old_dest   (old_dest),
        .old_data   (old_data),
        .young_dest (young_dest),
        .young_data (young_data)
    );

    always_comb begin
        flush_valid  = (decision == RET_FLUSH);
        flush_tag    = ptr_q.head;
        cmt0_valid   = (decision == RET_ONE) || (decision == RET_TWO);
        cmt1_valid   = (decision == RET_TWO);
        cmt0_dest    = old_dest;
        cmt0_data    = old_data;
        cmt1_dest    = young_dest;
        cmt1_data    = young_data;
        n_ret        = {1'b0, cmt0_valid} + {1'b0, cmt1_valid};

        disp_ready   = (ptr_q.count <= STALL_AT) && !flush_valid;
        int_go       = disp_int_valid && disp_ready;
        fp_go        = disp_fp_valid && disp_ready;
        n_go         = {1'b0, int_go} + {1'b0, fp_go};
        disp_int_tag = ptr_q.tail;
        disp_fp_tag  = disp_int_valid ? wrap_add(ptr_q.tail, 2'd1) : ptr_q.tail;

        release_mask = '0;
        if (cmt0_valid) release_mask[ptr_q.head] = 1'b1;
        if (cmt1_valid) release_mask[next_idx]   = 1'b1;

        ptr_d = ptr_q;
        if (flush_valid) begin
            ptr_d = '0;
        end else begin
            ptr_d.head  = wrap_add(ptr_q.head, n_ret);
            ptr_d.tail  = wrap_add(ptr_q.tail, n_go);
            ptr_d.count = ptr_q.count + CNT_W'(n_go) - CNT_W'(n_ret);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    rob_slots #(.DEPTH(DEPTH), .DATA_W(DATA_W), .REG_W(REG_W)) u_slots (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear_all    (flush_valid),
        .alloc_a_en   (int_go),
        .alloc_a_idx  (disp_int_tag),
        .alloc_a_dest (disp_int_dest),
        .alloc_b_en   (fp_go),
        .alloc_b_idx  (disp_fp_tag),
        .alloc_b_dest (disp_fp_dest),
        .cpl_a_en     (cpl_int_valid),
        .cpl_a_idx    (cpl_int_tag),
        .cpl_a_data   (cpl_int_data),
        .cpl_a_exc    (cpl_int_exc),
        .cpl_b_en     (cpl_fp_valid),
        .cpl_b_idx    (cpl_fp_tag),
        .cpl_b_data   (cpl_fp_data),
        .cpl_b_exc    (cpl_fp_exc),
        .release_mask (release_mask),
        .slot_valid   (slot_valid),
        .slot_done    (slot_done),
        .slot_exc     (slot_exc),
        .slot_dest    (slot_dest),
        .slot_data    (slot_data)
    );

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q.count <= FULL_AT); // R3

    AST_STALL_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_q.count > STALL_AT) |-> !disp_ready); // R3

    AST_FLUSH_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |=> (ptr_q.count == '0) && (disp_int_tag == '0)); // R7

    AST_PAIR_NEEDS_OLDER: assert property (@(posedge clk) disable iff (!rst_n)
        cmt1_valid |-> cmt0_valid); // R6

    AST_OLDEST_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_valid[ptr_q.head] && !slot_done[ptr_q.head]) |-> !cmt0_valid && !flush_valid); // R4

    AST_TAGS_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_int_valid && disp_fp_valid) |-> (disp_fp_tag != disp_int_tag)); // R2

endmodule

// File: tb/sim_commit_unit.sv
module sim_commit_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        disp_int_valid = 1'b0, disp_fp_valid = 1'b0;
    logic [4:0]  disp_int_dest = '0, disp_fp_dest = '0;
    logic        disp_ready;
    logic [2:0]  disp_int_tag, disp_fp_tag;
    logic        cpl_int_valid = 1'b0, cpl_int_exc = 1'b0;
    logic [2:0]  cpl_int_tag = '0;
    logic [31:0] cpl_int_data = '0;
    logic        cpl_fp_valid = 1'b0, cpl_fp_exc = 1'b0;
    logic [2:0]  cpl_fp_tag = '0;
    logic [31:0] cpl_fp_data = '0;
    logic        cmt0_valid, cmt1_valid, flush_valid;
    logic [4:0]  cmt0_dest, cmt1_dest;
    logic [31:0] cmt0_data, cmt1_data;
    logic [2:0]  flush_tag;

    always #4 clk = ~clk;   // 125 MHz

    commit_unit u0 (
        .clk(clk), .rst_n(rst_n),
        .disp_int_valid(disp_int_valid), .disp_int_dest(disp_int_dest),
        .disp_fp_valid(disp_fp_valid), .disp_fp_dest(disp_fp_dest),
        .disp_ready(disp_ready), .disp_int_tag(disp_int_tag), .disp_fp_tag(disp_fp_tag),
        .cpl_int_valid(cpl_int_valid), .cpl_int_tag(cpl_int_tag),
        .cpl_int_data(cpl_int_data), .cpl_int_exc(cpl_int_exc),
        .cpl_fp_valid(cpl_fp_valid), .cpl_fp_tag(cpl_fp_tag),
        .cpl_fp_data(cpl_fp_data), .cpl_fp_exc(cpl_fp_exc),
        .cmt0_valid(cmt0_valid), .cmt0_dest(cmt0_dest), .cmt0_data(cmt0_data),
        .cmt1_valid(cmt1_valid), .cmt1_dest(cmt1_dest), .cmt1_data(cmt1_data),
        .flush_valid(flush_valid), .flush_tag(flush_tag)
    );

    int checks = 0, errors = 0;
    int prog_q[$];          // tags in program order
    bit m_done[8], m_exc[8];
    int m_dest[8], m_data[8];
    int mtail = 0;
    bit mon_on = 1'b0;
    int commits_total = 0, pairs_seen = 0, flush_seen = 0, last_flush = -1;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic bit head_exc();
        if (prog_q.size() == 0) return 1'b0;
        return m_done[prog_q[0]] && m_exc[prog_q[0]];
    endfunction

    task automatic mark(input int tag, input int data, input bit exc);
        foreach (prog_q[i]) begin
            if (prog_q[i] == tag) begin
                m_done[tag] = 1'b1;
                m_exc[tag]  = exc;
                m_data[tag] = data;
            end
        end
    endtask

    // Driver: starts and ends one time unit after a rising edge
    task automatic drive(input bit iv, input int id, input bit fv, input int fd,
                         input bit civ, input int cit, input int cid, input bit cie,
                         input bit cfv, input int cft, input int cfd, input bit cfe);
        bit exp_rdy;
        disp_int_valid = iv; disp_int_dest = 5'(id);
        disp_fp_valid  = fv; disp_fp_dest  = 5'(fd);
        cpl_int_valid = civ; cpl_int_tag = 3'(cit); cpl_int_data = 32'(cid); cpl_int_exc = cie;
        cpl_fp_valid  = cfv; cpl_fp_tag  = 3'(cft); cpl_fp_data  = 32'(cfd); cpl_fp_exc  = cfe;
        #1;
        exp_rdy = (prog_q.size() <= 6) && !head_exc();
        if (iv || fv) begin
            chk(disp_ready === exp_rdy, "R3 dispatch readiness", disp_ready, exp_rdy);
            if (exp_rdy) begin
                if (iv) begin
                    chk(disp_int_tag == 3'(mtail), "R2 integer tag", disp_int_tag, mtail);
                    prog_q.push_back(mtail);
                    m_done[mtail] = 1'b0; m_exc[mtail] = 1'b0; m_dest[mtail] = id;
                    mtail = (mtail + 1) % 8;
                end
                if (fv) begin
                    chk(disp_fp_tag == 3'(mtail), "R2 floating-point tag", disp_fp_tag, mtail);
                    prog_q.push_back(mtail);
                    m_done[mtail] = 1'b0; m_exc[mtail] = 1'b0; m_dest[mtail] = fd;
                    mtail = (mtail + 1) % 8;
                end
            end
        end
        @(posedge clk); #1;
        disp_int_valid = 1'b0; disp_fp_valid = 1'b0;
        cpl_int_valid = 1'b0; cpl_fp_valid = 1'b0;
        cpl_int_exc = 1'b0; cpl_fp_exc = 1'b0;
        if (civ) mark(cit, cid, cie);
        if (cfv) mark(cft, cfd, cfe);
    endtask

    task automatic dispatch(input bit iv, input int id, input bit fv, input int fd);
        drive(iv, id, fv, fd, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic complete(input bit civ, input int cit, input int cid, input bit cie,
                            input bit cfv, input int cft, input int cfd, input bit cfe);
        drive(0, 0, 0, 0, civ, cit, cid, cie, cfv, cft, cfd, cfe);
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Monitor: samples outputs at the falling edge, pops the scoreboard
    always @(negedge clk) begin
        if (mon_on) begin
            bit e0, e1, ef;
            int f, s;
            e0 = 0; e1 = 0; ef = 0; f = -1; s = -1;
            if (prog_q.size() > 0) begin
                f = prog_q[0];
                if (m_done[f]) begin
                    if (m_exc[f]) ef = 1; else e0 = 1;
                end
            end
            if (e0 && prog_q.size() > 1) begin
                s  = prog_q[1];
                e1 = m_done[s] && !m_exc[s];
            end
            chk(flush_valid === ef, "R7 flush raised", flush_valid, ef);
            chk(cmt0_valid === e0, "R5 port 0 write in order", cmt0_valid, e0);
            chk(cmt1_valid === e1, "R6 port 1 write", cmt1_valid, e1);
            if (ef && flush_valid) begin
                chk(flush_tag == 3'(f), "R7 flush tag", flush_tag, f);
                flush_seen++;
                last_flush = f;
                prog_q.delete();
                mtail = 0;
                for (int k = 0; k < 8; k++) m_done[k] = 1'b0;
            end
            if (e0 && cmt0_valid) begin
                chk(cmt0_dest == 5'(m_dest[f]), "R5 port 0 dest", cmt0_dest, m_dest[f]);
                chk(cmt0_data == 32'(m_data[f]), "R5 port 0 data", cmt0_data, m_data[f]);
                void'(prog_q.pop_front());
                commits_total++;
            end
            if (e1 && cmt1_valid) begin
                chk(cmt1_dest == 5'(m_dest[s]), "R6 port 1 dest", cmt1_dest, m_dest[s]);
                chk(cmt1_data == 32'(m_data[s]), "R6 port 1 data", cmt1_data, m_data[s]);
                void'(prog_q.pop_front());
                commits_total++;
                pairs_seen++;
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int pairs_before, commits_before;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        // R1: empty after reset
        chk(disp_ready === 1'b1, "R1 ready after reset", disp_ready, 1);
        chk(cmt0_valid === 1'b0 && cmt1_valid === 1'b0, "R1 no writes after reset", cmt0_valid, 0);
        chk(flush_valid === 1'b0, "R1 no flush after reset", flush_valid, 0);
        chk(disp_int_tag == 3'd0, "R1 first tag", disp_int_tag, 0);
        mon_on = 1'b1;
        idle(1);

        // A: in-order completion, one write per cycle (R5)
        dispatch(1, 1, 1, 2);                          // tags 0,1
        complete(1, 0, 100, 0, 0, 0, 0, 0);
        idle(1);
        complete(0, 0, 0, 0, 1, 1, 101, 0);
        idle(1);

        // B: younger finishes first and waits (R4), then both retire together (R6)
        pairs_before = pairs_seen;
        dispatch(1, 3, 1, 4);                          // tags 2,3
        complete(0, 0, 0, 0, 1, 3, 203, 0);
        idle(3);
        complete(1, 2, 202, 0, 0, 0, 0, 0);
        idle(2);
        chk(pairs_seen == pairs_before + 1, "R6 pair retired together", pairs_seen, pairs_before + 1);

        // C: fill to eight with wrapping tags (R2), then stall (R3)
        dispatch(1, 5, 1, 6);                          // 4,5
        dispatch(1, 7, 1, 8);                          // 6,7
        dispatch(1, 9, 1, 10);                         // 0,1
        dispatch(1, 11, 1, 12);                        // 2,3
        dispatch(1, 13, 1, 14);                        // refused
        complete(1, 2, 302, 0, 1, 3, 303, 0);
        complete(1, 0, 300, 0, 1, 1, 301, 0);
        complete(1, 6, 306, 0, 1, 7, 307, 0);
        complete(1, 4, 304, 0, 1, 5, 305, 0);
        idle(6);
        dispatch(1, 15, 0, 0);                         // tag 4: refused request used none
        chk(mtail == 5, "R3 refused request consumed no tag", mtail, 5);
        complete(1, 4, 404, 0, 0, 0, 0, 0);
        idle(2);

        // D: clean head, excepting successor (R8)
        commits_before = commits_total;
        dispatch(1, 16, 1, 17);                        // 5,6
        dispatch(1, 18, 1, 19);                        // 7,0
        complete(1, 7, 507, 0, 1, 0, 500, 0);
        complete(1, 5, 505, 0, 1, 6, 506, 1);
        idle(4);
        chk(commits_total == commits_before + 1, "R8 older retires alone", commits_total, commits_before + 1);
        chk(last_flush == 6, "R8 flush for younger exception", last_flush, 6);

        // E: exception at head, tags restart at 0 (R7)
        complete(1, 7, 777, 0, 0, 0, 0, 0);            // stale slot, ignored
        dispatch(1, 20, 1, 21);                        // 0,1
        chk(prog_q.size() == 2 && prog_q[0] == 0, "R7 tags restart at zero", prog_q[0], 0);
        complete(0, 0, 0, 0, 1, 1, 611, 0);
        complete(1, 0, 610, 1, 0, 0, 0, 0);
        dispatch(1, 22, 0, 0);                         // during flush: refused
        idle(3);
        chk(last_flush == 0, "R7 head exception flush tag", last_flush, 0);
        chk(prog_q.size() == 0, "R7 younger entry discarded", prog_q.size(), 0);

        // F: completions to free slots ignored (R9)
        complete(1, 0, 900, 0, 1, 1, 901, 0);
        dispatch(1, 23, 1, 24);                        // 0,1 must still wait
        idle(3);
        chk(prog_q.size() == 2, "R9 stale completion ignored", prog_q.size(), 2);
        complete(1, 0, 910, 0, 1, 1, 911, 0);
        idle(2);

        // G: dispatch in the same cycle as a double retirement (R10)
        dispatch(1, 25, 1, 26);                        // 2,3
        dispatch(1, 27, 1, 28);                        // 4,5
        dispatch(1, 29, 1, 30);                        // 6,7
        complete(1, 2, 1002, 0, 1, 3, 1003, 0);
        dispatch(1, 31, 1, 1);                         // 0,1 while 2,3 retire
        chk(mtail == 2, "R10 dispatch alongside retirement", mtail, 2);
        complete(1, 5, 1005, 0, 1, 4, 1004, 0);
        complete(1, 7, 1007, 0, 1, 6, 1006, 0);
        complete(1, 1, 1001, 0, 1, 0, 1000, 0);
        idle(6);
        chk(prog_q.size() == 0, "R10 buffer drained", prog_q.size(), 0);
        chk(commits_total == 24, "R5 total writes", commits_total, 24);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule